// File: doc/BRIEF.md
# DSI Packet Formatter

This block converts command descriptors into the byte stream of single-lane DSI packets. It feeds a lane sequencer that follows it. Each descriptor carries four things: a virtual channel, a six-bit data type, two parameter bytes and a sixteen-bit word count. The data type decides whether the block builds a fixed four-byte short packet or a long packet. A long packet has a two-byte length header, the payload taken from a streaming input, and a two-byte trailing checksum. The block computes the six-bit header ECC itself.

The trailing checksum is chosen per descriptor. It is either all zeros, which suits receivers that ignore it, or a CRC-16 over the payload. The output is a valid/ready byte stream with a flag on the final byte of each packet. The payload input is held off while the header and the trailer are being sent. During the payload phase the block passes bytes straight from the payload input to the output.

The controller is a five-state machine:
- **IDLE** waits for a descriptor.
- **HDR** sends four header bytes, counted by a two-bit index.
- **PAY** forwards payload bytes.
- **SUM_LO** and **SUM_HI** send the checksum.

Its transitions are:
- IDLE→HDR when a descriptor is accepted.
- HDR→HDR when a header byte other than the fourth is accepted.
- HDR→IDLE after the fourth byte of a short packet.
- HDR→PAY after the fourth byte of a long packet with a non-zero word count.
- HDR→SUM_LO after the fourth byte of a long packet with a zero word count.
- PAY→PAY while payload bytes remain.
- PAY→SUM_LO on the last payload byte.
- SUM_LO→SUM_HI when the low checksum byte is accepted.
- SUM_HI→IDLE when the high checksum byte is accepted.

Top module: `dsi_pkt_fmt`

## Requirements
- R1: After reset `cmd_ready` is 1 and `out_valid` and `pl_ready` are 0. A descriptor is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. While idle, no output byte is offered and no payload byte is requested.
- R2: The first byte of every packet is the data identifier: bits 7:6 hold `cmd_vc` and bits 5:0 hold `cmd_dt`.
- R3: A short packet is exactly four bytes: identifier, `cmd_p0`, `cmd_p1`, ECC.
- R4: A long packet is sent in this order: identifier, the low byte of `cmd_wc`, the high byte of `cmd_wc`, ECC, then `cmd_wc` payload bytes, then two checksum bytes with the low byte first.
- R5: The ECC byte is built over the 24 bits formed by bytes 0..2 of the header, with byte 0 in bits 7:0. It uses the standard DSI Hamming parity equations. Its bits 7:6 are 0 (for example, header 15 11 00 gives ECC 0x25).
- R6: A data type is a long type when its bits 3:0 are 0x9, 0xC, 0xD or 0xE, and a short type otherwise. So 0x05 and 0x15 are short and 0x39 is long.
- R7: `pl_ready` is 0 outside the payload phase. Payload bytes appear on the output unchanged and in order.
- R8: When `cmd_sum_en` was 0 at acceptance, both checksum bytes are 0x00.
- R9: When `cmd_sum_en` was 1 at acceptance, the checksum is a CRC-16 over the payload bytes only. It uses polynomial x^16+x^12+x^5+1 in bit-reversed form (0x8408), seed 0xFFFF, and processes each byte least-significant bit first. An empty payload gives 0xFFFF.
- R10: A long packet with word count 0 is six bytes: the header followed directly by the checksum.
- R11: While a header or checksum byte is offered and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values on the next cycle.
- R12: `out_last` is 1 on the final byte of each packet and on no other byte. `cmd_ready` stays 0 from acceptance until that byte is taken, and is 1 on the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Descriptor offered |
| cmd_ready | output | 1 | Descriptor can be taken (idle) |
| cmd_vc | input | 2 | Virtual channel |
| cmd_dt | input | 6 | Data type |
| cmd_p0 | input | 8 | First parameter byte (short packets) |
| cmd_p1 | input | 8 | Second parameter byte (short packets) |
| cmd_wc | input | 16 | Payload byte count (long packets) |
| cmd_sum_en | input | 1 | 1: CRC-16 trailer, 0: zero trailer |
| pl_valid | input | 1 | Payload byte offered |
| pl_ready | output | 1 | Payload byte taken this cycle |
| pl_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
The hardest situations to reach from the ports all rely on stalling at the right moment:
- The output must stall exactly while the ECC byte or a checksum byte is offered.
- A payload source must be offering data while the header is still going out.
- A zero-length long packet must pass from the fourth header byte straight into the trailer.

The stimulus draws random ready and valid densities for each packet, some as low as 30 percent, so stalls land on every byte position. It presents payload from the very first cycle of a packet, so the header gating is tested. Directed zero-length packets with both trailer modes sit between the random ones.

// File: rtl/dsi_fmt_pkg.sv
package dsi_fmt_pkg;

    localparam int BYTE_W  = 8;
    localparam int WC_W    = 16;
    localparam int DT_W    = 6;
    localparam int VC_W    = 2;
    localparam int HDR_N   = 4;
    localparam int HIDX_W  = $clog2(HDR_N);
    localparam int ECC_W   = 6;
    localparam int HWORD_W = 3 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_SUM_LO,
        ST_SUM_HI
    } fmt_state_e;

    typedef struct packed {
        logic [VC_W-1:0]   vc;
        logic [DT_W-1:0]   dt;
        logic [BYTE_W-1:0] p0;
        logic [BYTE_W-1:0] p1;
        logic [WC_W-1:0]   wc;
        logic              sum_en;
    } fmt_desc_t;

    // Long-packet data types: low nibble 9 (generic/DCS long writes)
    // or C/D/E (pixel streams); every other type is short.
    function automatic logic dt_is_long(input logic [DT_W-1:0] dt);
        logic r;
        case (dt[3:0])
            4'h9, 4'hC, 4'hD, 4'hE: r = 1'b1;
            default:                r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dsi_hdr_gen.sv
module dsi_hdr_gen
    import dsi_fmt_pkg::*;
(
    input  fmt_desc_t                    desc,
    output logic [HDR_N-1:0][BYTE_W-1:0] hdr,
    output logic                         is_long
);
    // Row masks of the Hamming parity equations, one per ECC bit.
    localparam logic [ECC_W-1:0][HWORD_W-1:0] ECC_ROW = {
        24'hEFFC00, 24'hDF03F0, 24'hB8E38E,
        24'h749A6D, 24'hF2555B, 24'hF12CB7
    };

    logic [HWORD_W-1:0] word;
    logic [ECC_W-1:0]   ecc;

    always_comb begin
        is_long = dt_is_long(desc.dt);
        hdr[0]  = {desc.vc, desc.dt};
        hdr[1]  = is_long ? desc.wc[BYTE_W-1:0]        : desc.p0;
        hdr[2]  = is_long ? desc.wc[WC_W-1:WC_W-BYTE_W] : desc.p1;
        word    = {hdr[2], hdr[1], hdr[0]};
        hdr[3]  = {{(BYTE_W-ECC_W){1'b0}}, ecc};
    end

    for (genvar k = 0; k < ECC_W; k++) begin : g_par
        assign ecc[k] = ^(word & ECC_ROW[k]);
    end

endmodule

// File: rtl/dsi_crc16_acc.sv
module dsi_crc16_acc
    import dsi_fmt_pkg::*;
#(
    parameter int              CW       = 16,
    parameter logic [CW-1:0]   SEED     = '1,
    parameter logic [CW-1:0]   POLY_REF = 16'h8408
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [CW-1:0]     crc
);
    logic [CW-1:0] nxt;

    always_comb begin
        nxt = crc ^ {{(CW-BYTE_W){1'b0}}, din};
        for (int b = 0; b < BYTE_W; b++) begin
            nxt = nxt[0] ? ((nxt >> 1) ^ POLY_REF) : (nxt >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      crc <= SEED;
        else if (clr)    crc <= SEED;
        else if (upd)    crc <= nxt;
    end

    // R9: a new packet always starts the checksum from the seed
    p_seed_on_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == SEED));

endmodule

// File: rtl/dsi_fmt_ctrl.sv
module dsi_fmt_ctrl
    import dsi_fmt_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  fmt_desc_t                    desc_in,
    output fmt_desc_t                    desc_q,
    input  logic [HDR_N-1:0][BYTE_W-1:0] hdr,
    input  logic                         is_long,
    input  logic [WC_W-1:0]              crc,
    output logic                         crc_clr,
    output logic                         crc_upd,
    input  logic                         pl_valid,
    output logic                         pl_ready,
    input  logic [BYTE_W-1:0]            pl_data,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [BYTE_W-1:0]            out_data,
    output logic                         out_last
);
    localparam logic [HIDX_W-1:0] HDR_END = HIDX_W'(HDR_N - 1);

    fmt_state_e        state_q, state_d;
    logic [HIDX_W-1:0] idx_q, idx_d;
    logic [WC_W-1:0]   rem_q, rem_d;
    fmt_desc_t         desc_d;
    logic              fire;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            rem_q   <= '0;
            desc_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            rem_q   <= rem_d;
            desc_q  <= desc_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        rem_d   = rem_q;
        desc_d  = desc_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    desc_d  = desc_in;
                    idx_d   = '0;
                    state_d = ST_HDR;
                end
            end
            ST_HDR: begin
                if (fire) begin
                    if (idx_q == HDR_END) begin
                        if (!is_long)                state_d = ST_IDLE;
                        else if (desc_q.wc == '0)    state_d = ST_SUM_LO;
                        else begin
                            rem_d   = desc_q.wc;
                            state_d = ST_PAY;
                        end
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (fire) begin
                    rem_d = rem_q - 1'b1;
                    if (rem_q == WC_W'(1)) state_d = ST_SUM_LO;
                end
            end
            ST_SUM_LO: if (fire) state_d = ST_SUM_HI;
            ST_SUM_HI: if (fire) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready = 1'b0;
        pl_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr[idx_q];
                out_last  = !is_long && (idx_q == HDR_END);
            end
            ST_PAY: begin
                out_valid = pl_valid;
                out_data  = pl_data;
                pl_ready  = out_ready;
            end
            ST_SUM_LO: begin
                out_valid = 1'b1;
                out_data  = desc_q.sum_en ? crc[BYTE_W-1:0] : '0;
            end
            ST_SUM_HI: begin
                out_valid = 1'b1;
                out_data  = desc_q.sum_en ? crc[WC_W-1:WC_W-BYTE_W] : '0;
                out_last  = 1'b1;
            end
            default: ;
        endcase
        fire    = out_valid && out_ready;
        crc_clr = cmd_ready && cmd_valid;
        crc_upd = (state_q == ST_PAY) && pl_valid && out_ready;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!out_valid && !pl_ready));

    p_ecc_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR && idx_q == HDR_END) |-> (out_data[7:6] == 2'b00));

    p_pl_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PAY) |-> !pl_ready);

    p_trail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SUM_LO || state_q == ST_SUM_HI) && !desc_q.sum_en)
            |-> (out_data == '0));

    p_rem_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAY) |-> (rem_q != '0));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && state_q != ST_PAY)
            |=> (out_valid && $stable(out_data) && $stable(out_last)));

    p_last_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> cmd_ready);

endmodule

// File: rtl/dsi_pkt_fmt.sv
module dsi_pkt_fmt
    import dsi_fmt_pkg::*;
#(
    parameter logic [WC_W-1:0] CRC_SEED = 16'hFFFF,
    parameter logic [WC_W-1:0] CRC_POLY = 16'h8408
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [VC_W-1:0]   cmd_vc,
    input  logic [DT_W-1:0]   cmd_dt,
    input  logic [BYTE_W-1:0] cmd_p0,
    input  logic [BYTE_W-1:0] cmd_p1,
    input  logic [WC_W-1:0]   cmd_wc,
    input  logic              cmd_sum_en,
    input  logic              pl_valid,
    output logic              pl_ready,
    input  logic [BYTE_W-1:0] pl_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last
);
    fmt_desc_t                    desc_in, desc_q;
    logic [HDR_N-1:0][BYTE_W-1:0] hdr;
    logic                         is_long;
    logic [WC_W-1:0]              crc;
    logic                         crc_clr, crc_upd;

    always_comb begin
        desc_in.vc     = cmd_vc;
        desc_in.dt     = cmd_dt;
        desc_in.p0     = cmd_p0;
        desc_in.p1     = cmd_p1;
        desc_in.wc     = cmd_wc;
        desc_in.sum_en = cmd_sum_en;
    end

    dsi_hdr_gen u_hdr (
        .desc    (desc_q),
        .hdr     (hdr),
        .is_long (is_long)
    );

    dsi_crc16_acc #(
        .CW       (WC_W),
        .SEED     (CRC_SEED),
        .POLY_REF (CRC_POLY)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .upd   (crc_upd),
        .din   (pl_data),
        .crc   (crc)
    );

    dsi_fmt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .desc_in   (desc_in),
        .desc_q    (desc_q),
        .hdr       (hdr),
        .is_long   (is_long),
        .crc       (crc),
        .crc_clr   (crc_clr),
        .crc_upd   (crc_upd),
        .pl_valid  (pl_valid),
        .pl_ready  (pl_ready),
        .pl_data   (pl_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: tb/dsi_pkt_fmt_tb_top.sv
module dsi_pkt_fmt_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_vc = '0;
    logic [5:0]  cmd_dt = '0;
    logic [7:0]  cmd_p0 = '0;
    logic [7:0]  cmd_p1 = '0;
    logic [15:0] cmd_wc = '0;
    logic        cmd_sum_en = 1'b0;
    logic        pl_valid = 1'b0;
    logic        pl_ready;
    logic [7:0]  pl_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;

    int  n_cmp = 0;
    int  n_mis = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsi_pkt_fmt dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_vc(cmd_vc), .cmd_dt(cmd_dt), .cmd_p0(cmd_p0), .cmd_p1(cmd_p1),
        .cmd_wc(cmd_wc), .cmd_sum_en(cmd_sum_en),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Syndrome column of each header bit (P5..P0), R5
    function automatic logic [5:0] col_code(input int i);
        case (i)
            0: return 6'h07;  1: return 6'h0B;  2: return 6'h0D;  3: return 6'h0E;
            4: return 6'h13;  5: return 6'h15;  6: return 6'h16;  7: return 6'h19;
            8: return 6'h1A;  9: return 6'h1C; 10: return 6'h23; 11: return 6'h25;
           12: return 6'h26; 13: return 6'h29; 14: return 6'h2A; 15: return 6'h2C;
           16: return 6'h31; 17: return 6'h32; 18: return 6'h34; 19: return 6'h38;
           20: return 6'h1F; 21: return 6'h2F; 22: return 6'h37; default: return 6'h3B;
        endcase
    endfunction

    function automatic logic [7:0] ref_ecc(input logic [23:0] d);
        logic [5:0] s = '0;
        for (int i = 0; i < 24; i++) if (d[i]) s ^= col_code(i);
        return {2'b00, s};
    endfunction

    function automatic bit ref_long(input logic [5:0] dt);
        int n = int'(dt[3:0]);
        return (n == 9) || (n == 12) || (n == 13) || (n == 14);
    endfunction

    function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (q[k]) begin
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ q[k][b];
                c = c >> 1;
                if (fb) c ^= 16'h8408;
            end
        end
        return c;
    endfunction

    function automatic string byte_req(input int i, input bit lng, input int wc, input bit sen);
        if (i == 0) return "R2";
        if (i == 3) return "R5";
        if (i < 3)  return lng ? "R4" : "R3";
        if (i < 4 + wc) return "R7";
        return sen ? "R9" : "R8";
    endfunction

    task automatic run_pkt(input logic [1:0] vc, input logic [5:0] dt,
                           input logic [7:0] p0, input logic [7:0] p1,
                           input int wc, input bit sen,
                           input int rdy_pct, input int pv_pct);
        logic [7:0] pay[$];
        logic [7:0] exp_q[$];
        logic [7:0] got[$];
        bit         lastv[$];
        bit         lng = ref_long(dt);
        int         plen = lng ? wc : 0;
        int         pi = 0;
        bit         accepted = 0;
        bit         got_last = 0;
        bit         bad_rdy = 0;
        bit         bad_pl = 0;
        bit         prev_stall = 0;
        logic [7:0] prev_data = '0;
        int         guard = 0;
        logic [7:0] b1, b2;
        logic [15:0] cs;

        for (int k = 0; k < plen; k++) pay.push_back(8'($urandom));
        b1 = lng ? wc[7:0]  : p0;
        b2 = lng ? wc[15:8] : p1;
        exp_q.push_back({vc, dt});
        exp_q.push_back(b1);
        exp_q.push_back(b2);
        exp_q.push_back(ref_ecc({b2, b1, vc, dt}));
        if (lng) begin
            foreach (pay[k]) exp_q.push_back(pay[k]);
            cs = sen ? ref_crc(pay) : 16'h0000;
            exp_q.push_back(cs[7:0]);
            exp_q.push_back(cs[15:8]);
        end

        while (!got_last && guard < 20 * plen + 400) begin
            @(negedge clk);
            guard++;
            cmd_valid  = !accepted;
            cmd_vc     = vc;  cmd_dt = dt;  cmd_p0 = p0;  cmd_p1 = p1;
            cmd_wc     = 16'(wc);
            cmd_sum_en = sen;
            out_ready  = (int'($urandom % 100) < rdy_pct);
            if (pi < plen) begin
                pl_valid = (int'($urandom % 100) < pv_pct);
                pl_data  = pay[pi];
            end else begin
                pl_valid = 1'b1;
                pl_data  = 8'hA5;
            end
            #1;
            if (accepted && cmd_ready) bad_rdy = 1;
            if (accepted && pl_ready && (got.size() < 4 || got.size() >= 4 + plen)) bad_pl = 1;
            if (accepted && prev_stall && (got.size() < 4 || got.size() >= 4 + plen))
                chk(out_valid && out_data == prev_data, "R11", "held byte under stall",
                    out_data, prev_data);
            prev_stall = accepted && out_valid && !out_ready;
            prev_data  = out_data;
            if (!accepted && cmd_ready) accepted = 1;
            else if (out_valid && out_ready) begin
                got.push_back(out_data);
                lastv.push_back(out_last);
                if (out_last) got_last = 1;
            end
            if (pl_valid && pl_ready && pi < plen) pi++;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        pl_valid  = 1'b0;
        out_ready = 1'b0;
        #1;
        chk(cmd_ready == 1'b1, "R12", "ready after last byte", cmd_ready, 1);
        chk(!bad_rdy, "R12", "cmd_ready low during packet", bad_rdy, 0);
        chk(!bad_pl, "R7", "pl_ready low outside payload", bad_pl, 0);
        chk(got.size() == exp_q.size(), (lng && wc == 0) ? "R10" : "R6",
            $sformatf("packet length dt=%02h", dt), got.size(), exp_q.size());
        for (int i = 0; i < got.size() && i < exp_q.size(); i++) begin
            chk(got[i] == exp_q[i], byte_req(i, lng, plen, sen),
                $sformatf("byte %0d dt=%02h", i, dt), got[i], exp_q[i]);
            chk(lastv[i] == (i == exp_q.size() - 1), "R12",
                $sformatf("last flag byte %0d", i), lastv[i], (i == exp_q.size() - 1));
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            summary();
        end
    end

    initial begin
        logic [5:0] dts[4];
        void'($urandom(32'h00C0FFEE));
        dts[0] = 6'h05; dts[1] = 6'h15; dts[2] = 6'h39; dts[3] = 6'h29;
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        chk(cmd_ready == 1'b1, "R1", "cmd_ready in reset", cmd_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(pl_ready == 1'b0, "R1", "pl_ready in reset", pl_ready, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(cmd_ready && !out_valid, "R1", "idle after reset", {cmd_ready, out_valid}, 2);

        // R5 known vectors, R3 short packets
        run_pkt(2'd0, 6'h15, 8'h11, 8'h00, 0, 1'b0, 100, 100);
        run_pkt(2'd0, 6'h15, 8'h29, 8'h00, 0, 1'b0, 50, 100);
        run_pkt(2'd1, 6'h05, 8'h29, 8'h00, 0, 1'b1, 30, 100);
        // R10 zero-length long packet, both trailer modes (R8, R9)
        run_pkt(2'd0, 6'h39, 8'h00, 8'h00, 0, 1'b0, 40, 100);
        run_pkt(2'd2, 6'h39, 8'h00, 8'h00, 0, 1'b1, 40, 100);
        // R4 single byte and full-line payloads, R2 with vc 3
        run_pkt(2'd3, 6'h39, 8'h00, 8'h00, 1, 1'b1, 60, 60);
        run_pkt(2'd0, 6'h39, 8'h00, 8'h00, 480, 1'b1, 100, 100);
        run_pkt(2'd1, 6'h39, 8'h00, 8'h00, 5, 1'b0, 30, 30);
        // R6 classification of other long types
        run_pkt(2'd0, 6'h3E, 8'h00, 8'h00, 7, 1'b1, 70, 70);
        run_pkt(2'd0, 6'h2C, 8'h00, 8'h00, 3, 1'b0, 70, 70);

        for (int n = 0; n < 80; n++) begin
            logic [5:0] dt = (n % 5 == 4) ? 6'($urandom) : dts[$urandom % 4];
            run_pkt(2'($urandom), dt, 8'($urandom), 8'($urandom),
                    int'($urandom % 49), 1'($urandom), 30 + int'($urandom % 71),
                    30 + int'($urandom % 71));
        end
        summary();
    end

endmodule